// File: doc/BRIEF.md
# Dual-Slot Ethernet Transmit Engine

This block is the transmit half of a small Ethernet MAC. A host reaches it through an indexed register port. One port selects an 8-bit register index, and a second port reads or writes the register that index selects. The host loads a frame by writing 16-bit words into a 3072-byte transmit buffer through a write pointer. It then programs a frame length and sets a go bit. The engine reads the frame from the buffer, starting at its own transmit read pointer, and streams it out one byte at a time over a valid/ready interface that marks the last byte.

Completion is reported through two alternating slot flags, which clear when read, and through a latched transmit-done interrupt flag. A single interrupt line combines that flag with a mask register. After each frame the transmit read pointer moves to the next even byte address, so consecutive frames stay aligned for a 16-bit host.

Top module: `eth_tx_engine`

## Requirements
- R1: After reset, every register reads 0: control, status, interrupt status, interrupt mask, length, write pointer, transmit read pointer and the index. The slot index is 0, and tx_valid and irq are low.
- R2: Register map. With host_sel=0, a write loads the index from host_wdata[7:0] and a read returns the index. With host_sel=1, the index selects the register:
  - 0x00 control (bit 0 = go)
  - 0x01 status (bit 2 = slot 0 done, bit 3 = slot 1 done)
  - 0x02 interrupt status (bit 1 = transmit done)
  - 0x03 interrupt mask (bit 1 = transmit-done enable, bit 7 = autowrap)
  - 0x04 and 0x05 length, low byte and high byte
  - 0x06 and 0x07 write pointer, low byte and high byte
  - 0x08 and 0x09 transmit read pointer, low byte and high byte (read-only)
  - 0x0A incrementing data write
  - 0x0B fixed data write
  - Any other index reads 0.
- R3: An incrementing data write stores host_wdata[7:0] at the write pointer and host_wdata[15:8] at the write pointer plus 1, then adds 2 to the pointer. A fixed data write stores the same two bytes and leaves the pointer unchanged. A byte whose address is 0x0C00 or higher is dropped.
- R4: With mask bit 7 set, an incrementing write that takes the write pointer to 0x0C00 or above subtracts 0x0C00 from it. With bit 7 clear, the pointer keeps counting upward.
- R5: A control write with bit 0 set, while no frame is in flight, starts a frame of min(length, 3072) bytes read from the transmit read pointer. The byte address wraps from 0x0BFF to 0. Each byte is presented on tx_data with tx_valid, tx_last marks the final byte, and tx_valid and tx_last hold until tx_ready.
- R6: When a frame ends, the transmit read pointer becomes the address after the final byte, rounded up to an even value. A result of 0x0C00 becomes 0.
- R7: Completion takes effect in the cycle after the final byte handshake, or in the cycle after the request when the length is 0. At completion, control bit 0 clears, status bit (2 + slot) sets, interrupt status bit 1 sets, and the slot index toggles.
- R8: A data-port read of the status register returns its value and clears bits 3 and 2. A completion in the same cycle still sets its bit.
- R9: Writing 1 to interrupt status bit 1 clears it. Writing 0 to it leaves it set. A completion in the same cycle wins.
- R10: irq is high exactly when interrupt status bit 1 and mask bit 1 are both set. It follows register writes and completions with no added delay.
- R11: A control write while a frame is in flight is ignored. The frame is neither restarted nor cut short, and the control register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | 0 = index port, 1 = data port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; status read-clear occurs on the clock edge |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the selected port, combinational |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded properties watch, on every cycle, that a stalled byte keeps tx_valid and tx_last steady, and that each completion leaves an even, in-range read pointer and an idle engine. They also check that every completion sets the done flag and flips the slot, that a status read clears both slot flags, that an autowrapped write pointer stays inside the region, and that control writes during a frame change nothing. Other behaviour only shows up in whole scenarios against the reference model:
- the exact byte sequence across the 0x0BFF wrap;
- the 3072-byte length cap;
- the alternating slot bit pattern over several frames;
- dropped out-of-region bytes;
- the interplay of mask, flag and irq.

// File: rtl/txe_pkg.sv
package txe_pkg;
  // register indices on the data port
  localparam logic [7:0] IX_CTRL   = 8'h00;
  localparam logic [7:0] IX_STAT   = 8'h01;
  localparam logic [7:0] IX_IRQST  = 8'h02;
  localparam logic [7:0] IX_IRQMSK = 8'h03;
  localparam logic [7:0] IX_LENL   = 8'h04;
  localparam logic [7:0] IX_LENH   = 8'h05;
  localparam logic [7:0] IX_WPL    = 8'h06;
  localparam logic [7:0] IX_WPH    = 8'h07;
  localparam logic [7:0] IX_RPL    = 8'h08;
  localparam logic [7:0] IX_RPH    = 8'h09;
  localparam logic [7:0] IX_DWINC  = 8'h0A;
  localparam logic [7:0] IX_DWFIX  = 8'h0B;
  // bit positions the engine decodes
  localparam int CTRL_GO  = 0;
  localparam int MSK_DONE = 1;
  localparam int MSK_WRAP = 7;
  localparam int ST_DONE  = 1;
endpackage

// File: rtl/txe_sram.sv
module txe_sram #(
  parameter int PW = 16,
  parameter int RB = 3072
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [15:0]   wdata_i,
  input  logic [$clog2(RB)-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int AW = $clog2(RB);
  localparam logic [PW:0] LIM = (PW+1)'(RB);

  logic [7:0]  mem [RB];
  logic [PW:0] lane_addr [2];

  always_comb begin
    for (int b = 0; b < 2; b++) lane_addr[b] = {1'b0, waddr_i} + (PW+1)'(b);
  end

  // low byte lane 0, high byte lane 1; out-of-region lanes are dropped
  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int b = 0; b < 2; b++) begin
        if (lane_addr[b] < LIM) mem[lane_addr[b][AW-1:0]] <= wdata_i[8*b +: 8];
      end
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/txe_stream.sv
module txe_stream #(
  parameter int PW   = 16,
  parameter int RB   = 3072,
  parameter int MAXF = 3072
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] len_i,
  input  logic          tx_ready_i,
  output logic          tx_valid_o,
  output logic          tx_last_o,
  output logic [$clog2(RB)-1:0] raddr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [PW-1:0] rp_o
);
  localparam int AW = $clog2(RB);
  localparam int CW = $clog2(MAXF + 1);
  localparam logic [PW-1:0] MAXF_P = PW'(MAXF);
  localparam logic [AW:0]   RB_X   = (AW+1)'(RB);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] ptr_q, ptr_d, rp_q, rp_d;
  logic [AW:0]   up;

  always_comb begin
    busy_d     = busy_q;
    cnt_d      = cnt_q;
    ptr_d      = ptr_q;
    rp_d       = rp_q;
    tx_valid_o = busy_q && (cnt_q != '0);
    tx_last_o  = tx_valid_o && (cnt_q == CW'(1));
    done_o     = busy_q && (cnt_q == '0);
    up         = {1'b0, ptr_q} + {{AW{1'b0}}, ptr_q[0]};
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = (len_i > MAXF_P) ? CW'(MAXF) : len_i[CW-1:0];
      ptr_d  = rp_q;
    end else if (tx_valid_o && tx_ready_i) begin
      cnt_d = cnt_q - CW'(1);
      ptr_d = (ptr_q == AW'(RB - 1)) ? '0 : ptr_q + AW'(1);
    end else if (done_o) begin
      busy_d = 1'b0;
      rp_d   = (up >= RB_X) ? '0 : up[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      rp_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      rp_q   <= rp_d;
    end
  end

  assign raddr_o = ptr_q;
  assign busy_o  = busy_q;
  assign rp_o    = {{(PW-AW){1'b0}}, rp_q};

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_last_o)));
  // R6
  rp_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (rp_q[0] == 1'b0 && {1'b0, rp_q} < RB_X && !busy_q));
endmodule

// File: rtl/txe_regs.sv
module txe_regs
  import txe_pkg::*;
#(
  parameter int PW = 16,
  parameter int RB = 3072
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel_i,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [15:0]   host_wdata_i,
  output logic [15:0]   host_rdata_o,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [PW-1:0] rp_i,
  output logic          start_o,
  output logic [PW-1:0] len_o,
  output logic          mem_we_o,
  output logic [PW-1:0] mem_addr_o,
  output logic          irq_o
);
  localparam logic [PW:0] RB_X = (PW+1)'(RB);

  logic [7:0]    ix_q, ix_d, ctrl_q, ctrl_d, msk_q, msk_d;
  logic          txd_q, txd_d, slot_q, slot_d;
  logic [1:0]    nsr_q, nsr_d;
  logic [PW-1:0] wp_q, wp_d, len_q, len_d;
  logic [PW:0]   wp_inc;
  logic          data_wr, data_rd, ctrl_wr, stat_rd, inc_wr;

  assign data_wr = host_wr_i && host_sel_i;
  assign data_rd = host_rd_i && host_sel_i;
  assign ctrl_wr = data_wr && (ix_q == IX_CTRL);
  assign stat_rd = data_rd && (ix_q == IX_STAT);
  assign inc_wr  = data_wr && (ix_q == IX_DWINC);

  always_comb begin
    ix_d     = ix_q;
    ctrl_d   = ctrl_q;
    msk_d    = msk_q;
    txd_d    = txd_q;
    slot_d   = slot_q;
    nsr_d    = nsr_q;
    wp_d     = wp_q;
    len_d    = len_q;
    start_o  = 1'b0;
    mem_we_o = 1'b0;
    wp_inc   = {1'b0, wp_q} + (PW+1)'(2);
    if (host_wr_i && !host_sel_i) ix_d = host_wdata_i[7:0];
    if (data_wr) begin
      case (ix_q)
        IX_CTRL: if (!busy_i) begin
          ctrl_d  = host_wdata_i[7:0];
          start_o = host_wdata_i[CTRL_GO];
        end
        IX_IRQST:  if (host_wdata_i[ST_DONE]) txd_d = 1'b0;
        IX_IRQMSK: msk_d = host_wdata_i[7:0];
        IX_LENL:   len_d[7:0] = host_wdata_i[7:0];
        IX_LENH:   len_d[PW-1:8] = host_wdata_i[PW-9:0];
        IX_WPL:    wp_d[7:0] = host_wdata_i[7:0];
        IX_WPH:    wp_d[PW-1:8] = host_wdata_i[PW-9:0];
        IX_DWINC: begin
          mem_we_o = 1'b1;
          wp_d     = wp_inc[PW-1:0];
          if (msk_q[MSK_WRAP] && wp_inc >= RB_X) wp_d = PW'(wp_inc - RB_X);
        end
        IX_DWFIX: mem_we_o = 1'b1;
        default: ;
      endcase
    end
    if (stat_rd) nsr_d = 2'b00;
    if (done_i) begin
      ctrl_d[CTRL_GO] = 1'b0;
      if (slot_q) nsr_d[1] = 1'b1;
      else        nsr_d[0] = 1'b1;
      txd_d  = 1'b1;
      slot_d = ~slot_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ix_q   <= '0;
      ctrl_q <= '0;
      msk_q  <= '0;
      txd_q  <= 1'b0;
      slot_q <= 1'b0;
      nsr_q  <= '0;
      wp_q   <= '0;
      len_q  <= '0;
    end else begin
      ix_q   <= ix_d;
      ctrl_q <= ctrl_d;
      msk_q  <= msk_d;
      txd_q  <= txd_d;
      slot_q <= slot_d;
      nsr_q  <= nsr_d;
      wp_q   <= wp_d;
      len_q  <= len_d;
    end
  end

  always_comb begin
    host_rdata_o = '0;
    if (!host_sel_i) host_rdata_o[7:0] = ix_q;
    else begin
      case (ix_q)
        IX_CTRL:   host_rdata_o[7:0] = ctrl_q;
        IX_STAT:   host_rdata_o[3:2] = nsr_q;
        IX_IRQST:  host_rdata_o[ST_DONE] = txd_q;
        IX_IRQMSK: host_rdata_o[7:0] = msk_q;
        IX_LENL:   host_rdata_o[7:0] = len_q[7:0];
        IX_LENH:   host_rdata_o[PW-9:0] = len_q[PW-1:8];
        IX_WPL:    host_rdata_o[7:0] = wp_q[7:0];
        IX_WPH:    host_rdata_o[PW-9:0] = wp_q[PW-1:8];
        IX_RPL:    host_rdata_o[7:0] = rp_i[7:0];
        IX_RPH:    host_rdata_o[PW-9:0] = rp_i[PW-1:8];
        default: ;
      endcase
    end
  end

  assign len_o      = len_q;
  assign mem_addr_o = wp_q;
  assign irq_o      = txd_q && msk_q[MSK_DONE];

  // R11
  busy_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && ctrl_wr && !done_i) |=> (ctrl_q == $past(ctrl_q)));
  // R7
  done_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (txd_q && slot_q != $past(slot_q)));
  // R8
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done_i) |=> (nsr_q == 2'b00));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q[MSK_WRAP] && {1'b0, wp_q} < RB_X && inc_wr) |=> ({1'b0, wp_q} < RB_X));
endmodule

// File: rtl/eth_tx_engine.sv
module eth_tx_engine #(
  parameter int PTR_W        = 16,
  parameter int REGION_BYTES = 3072,
  parameter int MAX_FRAME    = 3072
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);
  localparam int AW = $clog2(REGION_BYTES);

  logic             start, busy, done, mem_we;
  logic [PTR_W-1:0] len, rp, waddr;
  logic [AW-1:0]    raddr;

  txe_regs #(.PW(PTR_W), .RB(REGION_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_sel_i(host_sel), .host_wr_i(host_wr), .host_rd_i(host_rd),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .busy_i(busy), .done_i(done), .rp_i(rp),
    .start_o(start), .len_o(len), .mem_we_o(mem_we), .mem_addr_o(waddr),
    .irq_o(irq)
  );

  txe_sram #(.PW(PTR_W), .RB(REGION_BYTES)) u_sram (
    .clk(clk), .we_i(mem_we), .waddr_i(waddr), .wdata_i(host_wdata),
    .raddr_i(raddr), .rdata_o(tx_data)
  );

  txe_stream #(.PW(PTR_W), .RB(REGION_BYTES), .MAXF(MAX_FRAME)) u_stream (
    .clk(clk), .rst_n(rst_n), .start_i(start), .len_i(len),
    .tx_ready_i(tx_ready), .tx_valid_o(tx_valid), .tx_last_o(tx_last),
    .raddr_o(raddr), .busy_o(busy), .done_o(done), .rp_o(rp)
  );
endmodule

// File: tb/test_eth_tx_engine.sv
`timescale 1ns/1ps
module test_eth_tx_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_wr, host_rd, tx_ready;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        tx_valid, tx_last, irq;
  logic [7:0]  tx_data;

  always #4 clk = ~clk;

  eth_tx_engine i_eth_tx_engine (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .irq(irq)
  );

  int nchk = 0, nfail = 0;
  int rdy_mode = 0;

  // behavioural reference model
  int m_ix, m_ctrl, m_msk, m_isr, m_nsr, m_slot, m_wp, m_rp, m_len;
  int m_busy, m_cnt, m_ptr;
  logic [7:0] m_mem [3072];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_rdata();
    if (!host_sel) return m_ix;
    case (m_ix)
      0: return m_ctrl;
      1: return m_nsr;
      2: return m_isr;
      3: return m_msk;
      4: return m_len & 255;
      5: return m_len >> 8;
      6: return m_wp & 255;
      7: return m_wp >> 8;
      8: return m_rp & 255;
      9: return m_rp >> 8;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ix = 0; m_ctrl = 0; m_msk = 0; m_isr = 0; m_nsr = 0; m_slot = 0;
      m_wp = 0; m_rp = 0; m_len = 0; m_busy = 0; m_cnt = 0; m_ptr = 0;
    end else begin
      int  wd, t;
      bit  done, hs, start;
      wd    = int'(host_wdata);
      done  = (m_busy != 0) && (m_cnt == 0);
      hs    = (m_busy != 0) && (m_cnt > 0) && tx_ready;
      start = 0;
      if (host_wr && !host_sel) m_ix = wd & 255;
      else if (host_wr && host_sel) begin
        case (m_ix)
          0: if (m_busy == 0) begin m_ctrl = wd & 255; start = wd[0]; end
          2: if (wd[1]) m_isr = 0;
          3: m_msk = wd & 255;
          4: m_len = (m_len & 'hFF00) | (wd & 255);
          5: m_len = (m_len & 'h00FF) | ((wd & 255) << 8);
          6: m_wp = (m_wp & 'hFF00) | (wd & 255);
          7: m_wp = (m_wp & 'h00FF) | ((wd & 255) << 8);
          10, 11: begin
            if (m_wp < 3072) m_mem[m_wp] = wd[7:0];
            if (m_wp + 1 < 3072) m_mem[m_wp + 1] = wd[15:8];
            if (m_ix == 10) begin
              t = m_wp + 2;
              if ((m_msk & 128) != 0 && t >= 3072) t = t - 3072;
              m_wp = t & 'hFFFF;
            end
          end
          default: ;
        endcase
      end
      if (host_rd && host_sel && m_ix == 1) m_nsr = 0;
      if (start) begin
        m_busy = 1; m_cnt = (m_len > 3072) ? 3072 : m_len; m_ptr = m_rp;
      end else if (hs) begin
        m_cnt--; m_ptr = (m_ptr + 1) % 3072;
      end else if (done) begin
        m_busy = 0;
        m_rp   = (m_ptr + (m_ptr & 1)) % 3072;
        m_ctrl = m_ctrl & ~1;
        m_nsr  = m_nsr | (1 << (2 + m_slot));
        m_isr  = 2;
        m_slot = m_slot ^ 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit ev;
      ev = (m_busy != 0) && (m_cnt > 0);
      chk("R5", "tx_valid", 32'(tx_valid), 32'(ev));
      chk("R5", "tx_last", 32'(tx_last), 32'(ev && m_cnt == 1));
      if (ev) chk("R5", "tx_data", 32'(tx_data), 32'(m_mem[m_ptr]));
      chk("R10", "irq", 32'(irq), 32'(((m_isr & m_msk & 3) != 0) ? 1 : 0));
      chk("R2", "host_rdata", 32'(host_rdata), 32'(m_rdata()));
    end
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0: tx_ready <= 1'b1;
      1: tx_ready <= ($urandom % 4) != 0;
      2: tx_ready <= ~tx_ready;
      default: tx_ready <= 1'b0;
    endcase
  end

  task automatic op(bit sel, bit wr, bit rd, int wd);
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = 16'(wd);
  endtask

  task automatic wreg(int ix, int val);
    op(0, 1, 0, ix); op(1, 1, 0, val); op(0, 0, 0, 0);
  endtask

  task automatic rreg(int ix, output int v);
    op(0, 1, 0, ix); op(1, 0, 1, 0); #2 v = int'(host_rdata); op(0, 0, 0, 0);
  endtask

  task automatic rchk(string req, int ix, int exp);
    int v;
    rreg(ix, v);
    chk(req, $sformatf("reg %0h", ix), 32'(v), 32'(exp));
  endtask

  task automatic send(int len);
    wreg(4, len & 255); wreg(5, len >> 8); wreg(0, 1);
    @(negedge clk);
    while (m_busy != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R5 watchdog: actual hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; host_sel = 0; host_wr = 0; host_rd = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #2;
    chk("R1", "tx_valid", 32'(tx_valid), 0);
    chk("R1", "irq", 32'(irq), 0);
    for (int i = 0; i < 10; i++) rchk("R1", i, 0);
    // R2 index readback and unmapped index
    op(0, 1, 0, 'h5A); op(0, 0, 1, 0); #2;
    chk("R2", "index read", 32'(host_rdata), 'h5A);
    rchk("R2", 'h20, 0);
    // R4 fill the whole region with autowrap on
    wreg(3, 'h80);
    op(0, 1, 0, 10);
    for (int i = 0; i < 1536; i++) op(1, 1, 0, (i * 'h0B0D + 'h1357) & 'hFFFF);
    op(0, 0, 0, 0);
    rchk("R4", 6, 0);
    rchk("R4", 7, 0);
    // R3 fixed write leaves the pointer
    wreg(6, 'h10);
    wreg(11, 'hBEEF);
    rchk("R3", 6, 'h10);
    // R4 no autowrap: pointer runs past the region, R3 bytes dropped
    wreg(3, 0);
    wreg(6, 'hFE); wreg(7, 'h0B);
    wreg(10, 'hA55A);
    rchk("R4", 7, 'h0C);
    rchk("R4", 6, 'h00);
    wreg(10, 'h1234);
    rchk("R3", 6, 'h02);
    // R5 frame 1: 5 bytes, random back-pressure
    wreg(3, 2);
    rdy_mode = 1;
    send(5);
    rchk("R6", 8, 6);
    rchk("R7", 2, 2);
    chk("R10", "irq after done", 32'(irq), 1);
    rchk("R7", 1, 'h04);
    rchk("R8", 1, 'h00);
    wreg(2, 1);
    rchk("R9", 2, 2);
    wreg(2, 2);
    rchk("R9", 2, 0);
    chk("R10", "irq after clear", 32'(irq), 0);
    // R7 slot alternation, zero-length frame
    rdy_mode = 2;
    send(3);
    rchk("R6", 8, 10);
    send(0);
    rchk("R7", 1, 'h0C);
    rchk("R7", 0, 0);
    // R11 control writes during a stalled frame
    rdy_mode = 3;
    wreg(4, 20); wreg(5, 0); wreg(0, 1);
    repeat (3) @(negedge clk);
    wreg(0, 0);
    rchk("R11", 0, 1);
    wreg(0, 1);
    rdy_mode = 0;
    @(negedge clk);
    while (m_busy != 0) @(negedge clk);
    rchk("R11", 8, 30);
    rdy_mode = 1;
    send(7);
    rchk("R6", 8, 38);
    // R5 length cap and address wrap
    rdy_mode = 0;
    send('h0D00);
    rchk("R5", 8, 38);
    rchk("R5", 9, 0);
    // R6 rounding at the end of the region
    send(3033);
    rchk("R6", 8, 0);
    rchk("R6", 9, 0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule